// File: doc/BRIEF.md
# Two-Wire Target Front-End with Pin-Strapped Address

This block is the serial front-end of a small command-driven peripheral. It watches a two-wire serial bus (SCL and SDA) through the system clock, cleans both lines with a synchroniser and a glitch filter, and recognises START, repeated START and STOP. It answers one 7-bit target address. The top five bits of that address are fixed. The low two bits come from a strap pin that can be tied low, tied high or left floating.

In a write transaction the controller sends the address and then any number of byte pairs. Each pair, high byte first, is handed to the command logic as one 16-bit word with a single-cycle strobe. For a read, the command logic first loads a readback word through a load port. The next read transaction returns that word as two bytes and then discards it. While the command logic reports busy, the address byte is left unacknowledged, so a controller can poll until the internal operation finishes. SDA is driven only through an open-drain pull-low enable.

Top module: `i2c_tgt_pinaddr`

## Requirements
- R1: The target address is 01011 followed by two bits chosen by `addr_pin`: code 00 (tied low) gives 11, code 01 (tied high) gives 00, and code 10 or 11 (floating) gives 10. A matching address byte is acknowledged by pulling SDA low during the ninth clock. Any other address is not acknowledged.
- R2: The general call address 0000000 and the 10-bit addressing prefix 11110xx are never acknowledged.
- R3: In a write, every data byte is acknowledged and is taken MSB first. The first byte of a pair becomes bits 15:8 of the word. When the second byte completes, `cmd_valid` pulses for one cycle with the word on `cmd_word`, in the cycle in which the acknowledge for that byte starts.
- R4: One address phase may be followed by several byte pairs. Each pair is delivered as its own strobe, in bus order.
- R5: While `busy` is high when the address byte completes, the address is not acknowledged, whether it is a read or a write. Once `busy` is low, the next address attempt is acknowledged.
- R6: A pulse on `rd_load` captures `rd_word`. The next read transaction returns bits 15:8 and then bits 7:0, MSB first.
- R7: If the controller does not acknowledge the first read byte, the target does not drive SDA on any later clock of that transaction.
- R8: A read consumes the loaded word. A later read with no new `rd_load` returns all ones, because SDA is released.
- R9: A START or STOP before a word is complete discards the partial word without a strobe. A repeated START begins a new address phase.
- R10: A pulse on SCL or SDA shorter than `FILT_CYCLES` clock cycles has no effect on the bus state.
- R11: `sda_oe` changes only while the filtered SCL is low, and it is low in the cycle after a STOP is detected.
- R12: After reset `sda_oe` and `cmd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level (wired bus value) |
| sda_oe | output | 1 | Pull SDA low when high |
| addr_pin | input | 2 | Strap level: 00 low, 01 high, 10/11 floating |
| busy | input | 1 | Command logic busy; address is not acknowledged |
| rd_load | input | 1 | Capture `rd_word` as the next readback word |
| rd_word | input | 16 | Readback word |
| cmd_valid | output | 1 | One-cycle strobe for a received word |
| cmd_word | output | 16 | Received 16-bit command word |

## Verification
Each pin edge reaches the bus logic after two synchroniser flops and `FILT_CYCLES` filter cycles. The bus logic acts one cycle later, so with the default settings the acknowledge enable and the word strobe follow the falling SCL of the relevant ninth clock by about ten cycles. The bench holds every SCL phase for sixteen cycles, well beyond that delay. It samples SDA for acknowledges and read bits in the middle of the SCL high phase. Word strobes are collected by a monitor on the falling clock edge and compared after the STOP, so no check depends on the exact cycle of a strobe. Glitches are three cycles long, well inside the filter window.

// File: rtl/i2c_tgt_pkg.sv
// Shared types and constants for the pin-strapped serial target.
// Assumes 7-bit addressing only; the strap pin is already decoded to a 2-bit level code.
package i2c_tgt_pkg;

    localparam int          ADDR_W   = 7;
    localparam logic [4:0]  ADDR_TOP = 5'b01011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } tgt_state_t;

    // Maps the strap level code to the low two address bits.
    function automatic logic [1:0] strap_bits(input logic [1:0] lvl);
        case (lvl)
            2'b00:   strap_bits = 2'b11;
            2'b01:   strap_bits = 2'b00;
            default: strap_bits = 2'b10;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
// Two-flop synchroniser followed by a persistence filter for one bus line.
// The output follows the input only after it has differed for FILT_CYCLES samples.
// Assumes the line idles high, so the output resets to INIT.
module i2c_line_filter #(
    parameter int   FILT_CYCLES = 7,
    parameter logic INIT        = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flt_o
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

    logic             sync_q1;
    logic             sync_q2;
    logic [CNT_W-1:0] cnt_q;

    // Bring the pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q1 <= INIT;
            sync_q2 <= INIT;
        end else begin
            sync_q1 <= raw_i;
            sync_q2 <= sync_q1;
        end
    end

    // Accept a new level only after it persists for the whole window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            flt_o <= INIT;
        end else if (sync_q2 == flt_o) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            flt_o <= sync_q2;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_bus_events.sv
// Turns the filtered SCL and SDA levels into one-cycle bus events.
// START and STOP are SDA edges while SCL is high; both inputs are already filtered.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_evt,
    output logic stop_evt,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_d;
    logic sda_d;

    // Keep the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    // Decode the edges into events.
    always_comb begin
        scl_rise  = scl_f & ~scl_d;
        scl_fall  = ~scl_f & scl_d;
        start_evt = scl_f & scl_d & sda_d & ~sda_f;
        stop_evt  = scl_f & scl_d & ~sda_d & sda_f;
    end

endmodule

// File: rtl/i2c_tgt_link.sv
// Byte-level target protocol: address match, write pairing, readback and acknowledges.
// Assumes the events come from filtered lines and that WORD_W is two bytes.
// START or STOP aborts any partial byte or word; a readback word is used once.
module i2c_tgt_link
    import i2c_tgt_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_f,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              busy,
    input  logic              rd_load,
    input  logic [WORD_W-1:0] rd_word,
    output logic              sda_oe,
    output logic              cmd_valid,
    output logic [WORD_W-1:0] cmd_word
);
    localparam int HALF_W = WORD_W / 2;
    localparam int BCNT_W = $clog2(HALF_W + 1);
    localparam logic [BCNT_W-1:0] BCNT_FULL = BCNT_W'(HALF_W);

    tgt_state_t        state_q;
    logic [HALF_W-1:0] sh_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic [HALF_W-1:0] hi_q;
    logic              second_q;
    logic              rnw_q;
    logic              mack_q;
    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rd_buf_q;
    logic              armed_q;
    logic              byte_done;
    logic              addr_hit;

    // A byte is complete at the falling SCL after its eighth bit.
    always_comb begin
        byte_done = scl_fall && (bcnt_q == BCNT_FULL);
        addr_hit  = (sh_q[HALF_W-1:1] == dev_addr) && !busy;
    end

    // Hold the readback word until a read transaction takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_buf_q <= '0;
            armed_q  <= 1'b0;
        end else if (rd_load) begin
            rd_buf_q <= rd_word;
            armed_q  <= 1'b1;
        end else if (state_q == ST_ADDR_ACK && scl_fall && rnw_q) begin
            armed_q  <= 1'b0;
        end
    end

    // Protocol sequencer, one transition per bus event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sh_q      <= '0;
            bcnt_q    <= '0;
            hi_q      <= '0;
            second_q  <= 1'b0;
            rnw_q     <= 1'b0;
            mack_q    <= 1'b0;
            tx_q      <= '0;
            sda_oe    <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_word  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (start_evt) begin
                state_q  <= ST_ADDR;
                bcnt_q   <= '0;
                second_q <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (stop_evt) begin
                state_q  <= ST_IDLE;
                second_q <= 1'b0;
                sda_oe   <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            sh_q   <= {sh_q[HALF_W-2:0], sda_f};
                            bcnt_q <= bcnt_q + 1'b1;
                        end else if (byte_done && state_q == ST_ADDR) begin
                            if (addr_hit) begin
                                sda_oe  <= 1'b1;
                                rnw_q   <= sh_q[0];
                                state_q <= ST_ADDR_ACK;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else if (byte_done) begin
                            sda_oe  <= 1'b1;
                            state_q <= ST_WR_ACK;
                            if (!second_q) begin
                                hi_q     <= sh_q;
                                second_q <= 1'b1;
                            end else begin
                                cmd_valid <= 1'b1;
                                cmd_word  <= {hi_q, sh_q};
                                second_q  <= 1'b0;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bcnt_q <= '0;
                            if (rnw_q) begin
                                tx_q     <= armed_q ? rd_buf_q : '1;
                                sh_q     <= armed_q ? rd_buf_q[WORD_W-1:HALF_W] : '1;
                                sda_oe   <= armed_q ? ~rd_buf_q[WORD_W-1] : 1'b0;
                                second_q <= 1'b0;
                                state_q  <= ST_RD;
                            end else begin
                                sda_oe  <= 1'b0;
                                state_q <= ST_WR;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bcnt_q  <= '0;
                            state_q <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            bcnt_q <= bcnt_q + 1'b1;
                        end else if (byte_done) begin
                            sda_oe  <= 1'b0;
                            state_q <= ST_RD_ACK;
                        end else if (scl_fall) begin
                            sda_oe <= ~sh_q[HALF_W-2];
                            sh_q   <= {sh_q[HALF_W-2:0], 1'b1};
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_f;
                        end else if (scl_fall) begin
                            if (mack_q && !second_q) begin
                                sh_q     <= tx_q[HALF_W-1:0];
                                sda_oe   <= ~tx_q[HALF_W-1];
                                bcnt_q   <= '0;
                                second_q <= 1'b1;
                                state_q  <= ST_RD;
                            end else begin
                                sda_oe  <= 1'b0;
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_tgt_pinaddr.sv
// Top of the pin-strapped serial target: line filters, event decode and protocol.
// Assumes SDA is open-drain; sda_oe pulls the line low and nothing drives it high.
module i2c_tgt_pinaddr
    import i2c_tgt_pkg::*;
#(
    parameter int FILT_CYCLES = 7,
    parameter int WORD_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        addr_pin,
    input  logic              busy,
    input  logic              rd_load,
    input  logic [WORD_W-1:0] rd_word,
    output logic              cmd_valid,
    output logic [WORD_W-1:0] cmd_word
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_v;
    logic [N_LINES-1:0] flt_v;
    logic               scl_flt;
    logic               sda_flt;
    logic               start_evt;
    logic               stop_evt;
    logic               scl_rise;
    logic               scl_fall;
    logic [ADDR_W-1:0]  dev_addr;

    // Gather the pins and build the device address from the strap.
    always_comb begin
        raw_v    = {scl_i, sda_i};
        scl_flt  = flt_v[1];
        sda_flt  = flt_v[0];
        dev_addr = {ADDR_TOP, strap_bits(addr_pin)};
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_line_filter #(
            .FILT_CYCLES(FILT_CYCLES),
            .INIT       (1'b1)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw_i(raw_v[g]),
            .flt_o(flt_v[g])
        );
    end

    i2c_bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_flt),
        .sda_f    (sda_flt),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    i2c_tgt_link #(
        .WORD_W(WORD_W)
    ) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_f    (sda_flt),
        .dev_addr (dev_addr),
        .busy     (busy),
        .rd_load  (rd_load),
        .rd_word  (rd_word),
        .sda_oe   (sda_oe),
        .cmd_valid(cmd_valid),
        .cmd_word (cmd_word)
    );

endmodule

// File: rtl/i2c_tgt_pinaddr_chk.sv
// Property checker for the serial target, bound to the top module.
// Observes the filtered SCL, the STOP event and the block outputs.
module i2c_tgt_pinaddr_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_f,
    input logic stop_evt,
    input logic sda_oe,
    input logic cmd_valid
);
    // The word strobe starts together with the acknowledge of its second byte.
    p_ack_with_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> sda_oe);

    // The word strobe falls in the low phase of SCL.
    p_strobe_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !scl_f);

    // Each word gives exactly one strobe cycle.
    p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // The SDA enable only moves while SCL is low.
    p_sda_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_f);

    // A STOP releases the line.
    p_release_on_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

endmodule

bind i2c_tgt_pinaddr i2c_tgt_pinaddr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_flt),
    .stop_evt (stop_evt),
    .sda_oe   (sda_oe),
    .cmd_valid(cmd_valid)
);

// File: tb/i2c_tgt_pinaddr_test.sv
`timescale 1ns/1ps
module i2c_tgt_pinaddr_test;
    localparam int Q  = 16;
    localparam int GL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        busy = 1'b0;
    logic        rd_load = 1'b0;
    logic [15:0] rd_word = '0;
    logic [1:0]  pin_sel = 2'b00;
    logic        sda_oe;
    logic        cmd_valid;
    logic [15:0] cmd_word;
    wire         sda_line = sda_m & ~sda_oe;

    int          n_chk = 0;
    int          n_err = 0;
    int          n_words = 0;
    logic [15:0] got [0:63];

    always #4 clk = ~clk;

    i2c_tgt_pinaddr uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_pin(pin_sel), .busy(busy), .rd_load(rd_load), .rd_word(rd_word),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word)
    );

    // Collect word strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (n_words < 64) got[n_words] = cmd_word;
            n_words = n_words + 1;
        end
    end

    function automatic logic [6:0] exp_addr(input logic [1:0] p);
        case (p)
            2'b00:   exp_addr = 7'b0101111;
            2'b01:   exp_addr = 7'b0101100;
            default: exp_addr = 7'b0101110;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); wq();
        sda_m = 1'b0; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input bit gl);
        for (int i = 7; i > 7 - n; i--) begin
            wq();
            if (gl) begin scl_m = 1'b1; repeat (GL) @(negedge clk); scl_m = 1'b0; end
            sda_m = b[i]; wq(); scl_m = 1'b1; wq();
            if (gl && b[i]) begin sda_m = 1'b0; repeat (GL) @(negedge clk); sda_m = 1'b1; end
            wq(); scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit gl, output bit ack);
        send_bits(b, 8, gl);
        sda_m = 1'b1; wq(); wq(); scl_m = 1'b1; wq();
        ack = ~sda_line;
        wq(); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); wq(); scl_m = 1'b1; wq();
            b[i] = sda_line;
            wq(); scl_m = 1'b0;
        end
        wq(); sda_m = ~mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic addr_phase(input logic [6:0] a, input bit rnw, output bit ack);
        bus_start();
        send_byte({a, rnw}, 1'b0, ack);
    endtask

    task automatic load_rd(input logic [15:0] w);
        @(negedge clk); rd_word = w; rd_load = 1'b1;
        @(negedge clk); rd_load = 1'b0;
    endtask

    task automatic write_word(input logic [15:0] w, input string req);
        bit ack;
        send_byte(w[15:8], 1'b0, ack); chk(ack, req, {31'd0, ack}, 1);
        send_byte(w[7:0],  1'b0, ack); chk(ack, req, {31'd0, ack}, 1);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        bit          ack;
        int          base;
        logic [15:0] w;
        logic [15:0] ws [0:2];
        logic [7:0]  hb;
        logic [7:0]  lb;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(sda_oe == 1'b0, "R12", {31'd0, sda_oe}, 0);
        chk(cmd_valid == 1'b0, "R12", {31'd0, cmd_valid}, 0);

        // R1 every strap code, matching and neighbouring addresses
        for (int p = 0; p < 4; p++) begin
            pin_sel = 2'(p);
            addr_phase(exp_addr(pin_sel), 1'b0, ack); bus_stop();
            chk(ack, "R1", {31'd0, ack}, 1);
            addr_phase(exp_addr(pin_sel) ^ 7'h01, 1'b0, ack); bus_stop();
            chk(!ack, "R1", {31'd0, ack}, 0);
            addr_phase(exp_addr(pin_sel) ^ 7'h10, 1'b1, ack); bus_stop();
            chk(!ack, "R1", {31'd0, ack}, 0);
        end

        // R2 general call and 10-bit prefix
        pin_sel = 2'b10;
        addr_phase(7'h00, 1'b0, ack); bus_stop();
        chk(!ack, "R2", {31'd0, ack}, 0);
        addr_phase(7'b1111000, 1'b0, ack); bus_stop();
        chk(!ack, "R2", {31'd0, ack}, 0);
        addr_phase(7'b1111011, 1'b1, ack); bus_stop();
        chk(!ack, "R2", {31'd0, ack}, 0);

        // R3 random single-word writes on random straps
        for (int k = 0; k < 10; k++) begin
            pin_sel = 2'($urandom_range(0, 3));
            w = 16'($urandom);
            base = n_words;
            addr_phase(exp_addr(pin_sel), 1'b0, ack);
            chk(ack, "R3", {31'd0, ack}, 1);
            write_word(w, "R3");
            bus_stop();
            chk(n_words == base + 1, "R3", n_words, base + 1);
            chk(got[base] == w, "R3", {16'd0, got[base]}, {16'd0, w});
            chk(sda_oe == 1'b0, "R11", {31'd0, sda_oe}, 0);
        end

        // R4 three words in one transaction
        pin_sel = 2'b01;
        base = n_words;
        addr_phase(exp_addr(pin_sel), 1'b0, ack);
        for (int k = 0; k < 3; k++) begin
            ws[k] = 16'($urandom);
            write_word(ws[k], "R4");
        end
        bus_stop();
        chk(n_words == base + 3, "R4", n_words, base + 3);
        for (int k = 0; k < 3; k++)
            chk(got[base+k] == ws[k], "R4", {16'd0, got[base+k]}, {16'd0, ws[k]});

        // R5 busy withholds address acknowledge, then poll succeeds
        busy = 1'b1;
        for (int k = 0; k < 2; k++) begin
            addr_phase(exp_addr(pin_sel), 1'(k), ack); bus_stop();
            chk(!ack, "R5", {31'd0, ack}, 0);
        end
        busy = 1'b0;
        base = n_words;
        addr_phase(exp_addr(pin_sel), 1'b0, ack);
        chk(ack, "R5", {31'd0, ack}, 1);
        write_word(16'h3C5A, "R5");
        bus_stop();
        chk(n_words == base + 1 && got[base] == 16'h3C5A, "R5", {16'd0, got[base]}, 32'h3C5A);

        // R6 readback of loaded words
        for (int k = 0; k < 3; k++) begin
            w = (k == 0) ? 16'h8001 : 16'($urandom);
            load_rd(w);
            addr_phase(exp_addr(pin_sel), 1'b1, ack);
            chk(ack, "R6", {31'd0, ack}, 1);
            recv_byte(1'b1, hb);
            recv_byte(1'b0, lb);
            bus_stop();
            chk({hb, lb} == w, "R6", {16'd0, hb, lb}, {16'd0, w});
        end

        // R8 second read without reload returns all ones
        addr_phase(exp_addr(pin_sel), 1'b1, ack);
        recv_byte(1'b1, hb); recv_byte(1'b0, lb); bus_stop();
        chk({hb, lb} == 16'hFFFF, "R8", {16'd0, hb, lb}, 32'hFFFF);

        // R7 controller NACK on first byte: no drive afterwards
        load_rd(16'h5500);
        addr_phase(exp_addr(pin_sel), 1'b1, ack);
        recv_byte(1'b0, hb);
        recv_byte(1'b0, lb);
        bus_stop();
        chk(hb == 8'h55, "R7", {24'd0, hb}, 32'h55);
        chk(lb == 8'hFF, "R7", {24'd0, lb}, 32'hFF);

        // R9 STOP after one byte, and STOP in mid-byte, deliver nothing
        base = n_words;
        addr_phase(exp_addr(pin_sel), 1'b0, ack);
        send_byte(8'h12, 1'b0, ack);
        bus_stop();
        addr_phase(exp_addr(pin_sel), 1'b0, ack);
        send_byte(8'h34, 1'b0, ack);
        send_bits(8'hF0, 4, 1'b0);
        bus_stop();
        chk(n_words == base, "R9", n_words, base);

        // R9 repeated START in mid-byte restarts with a new address phase
        base = n_words;
        addr_phase(exp_addr(pin_sel), 1'b0, ack);
        send_byte(8'hAA, 1'b0, ack);
        send_bits(8'h0F, 3, 1'b0);
        addr_phase(exp_addr(pin_sel), 1'b0, ack);
        chk(ack, "R9", {31'd0, ack}, 1);
        write_word(16'h6E21, "R9");
        bus_stop();
        chk(n_words == base + 1 && got[base] == 16'h6E21, "R9", {16'd0, got[base]}, 32'h6E21);

        // R9 write then repeated START into a read
        load_rd(16'hC3A7);
        base = n_words;
        addr_phase(exp_addr(pin_sel), 1'b0, ack);
        write_word(16'h0102, "R9");
        addr_phase(exp_addr(pin_sel), 1'b1, ack);
        recv_byte(1'b1, hb); recv_byte(1'b0, lb); bus_stop();
        chk(got[base] == 16'h0102, "R9", {16'd0, got[base]}, 32'h0102);
        chk({hb, lb} == 16'hC3A7, "R6", {16'd0, hb, lb}, 32'hC3A7);

        // R10 short pulses on both lines are ignored
        base = n_words;
        addr_phase(exp_addr(pin_sel), 1'b0, ack);
        send_byte(8'hA5, 1'b1, ack);
        chk(ack, "R10", {31'd0, ack}, 1);
        send_byte(8'hFF, 1'b1, ack);
        chk(ack, "R10", {31'd0, ack}, 1);
        bus_stop();
        chk(n_words == base + 1, "R10", n_words, base + 1);
        chk(got[base] == 16'hA5FF, "R10", {16'd0, got[base]}, 32'hA5FF);
        chk(sda_oe == 1'b0, "R11", {31'd0, sda_oe}, 0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule